// File: doc/BRIEF.md
# Successive-Approximation Offset Trim Controller

This block searches for the trim word of a current-steering compensation DAC that cancels the static offset of an analog stage. The only measurement it has is a one-bit comparator that reports the sign of the remaining imperfection. On a start request it clears the whole word and then settles one bit at a time, from the most significant bit down to the least significant. For each bit it raises the bit, waits a programmable number of clocks so the analog path can settle, and then reads the comparator. If the comparator shows that the correction now overshoots, it drops the bit. Otherwise it keeps the bit.

The word is a set of plain logic levels that drive the DAC switches directly. After the last decision the controller keeps that word unchanged until the next start request. The residual offset then lies inside one DAC step, so the DAC resolution sets the trim accuracy. The search tolerates a redundant (sub-binary) DAC because it only needs the comparator sign at each step.

Top module: `offset_trim_sar`

## Requirements
- R1: After a synchronous reset, `code_o` is all zeros and `busy_o` and `done_o` are low.
- R2: A start pulse accepted while idle makes `busy_o` high from the next cycle on. In that same cycle `code_o` holds only its most significant bit set.
- R3: Bits are decided one at a time from the MSB down to the LSB. While busy, no bit below the bit under test is ever set.
- R4: At the decision for a bit, a comparator value of 1 (correction too large) clears that bit and a value of 0 keeps it. A comparator stuck at 1 gives a final word of 0. A comparator stuck at 0 gives all ones.
- R5: Each bit is given W = max(`settle_i`, 4) clocks of settling, with `settle_i` sampled at the start. `busy_o` therefore stays high for exactly CODE_W × W cycles.
- R6: In the cycle after the LSB decision, `busy_o` is low and `done_o` is high for exactly one cycle. `busy_o` and `done_o` are never high together.
- R7: While idle, `code_o` does not change whatever the comparator does.
- R8: A start pulse received while busy is ignored. Neither the run length nor the final word changes.
- R9: With an ideal binary DAC in the loop, the final word is the largest code not above the offset, clamped to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a calibration run |
| comp_i | input | 1 | Comparator sign; 1 means the correction exceeds the offset |
| settle_i | input | CNT_W | Settling clocks per bit (values below 4 act as 4) |
| code_o | output | CODE_W | Trim word driving the DAC switches |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |

## Verification
The bench builds the block with its defaults: a 10-bit word and an 8-bit settle count. A full run is therefore 40 to a few hundred clocks, short enough that many offsets can be swept. Settle values of 0, 2, 4, 5 and 6 reach both the clamp to the minimum wait and longer waits. Offsets at zero, mid-scale, mid-scale minus one, full scale and beyond full scale exercise every keep and clear path. The bench also covers stuck comparators and the hold after completion.

// File: rtl/sac_pkg.sv
package sac_pkg;

    // Shortest settling wait the controller will ever apply per bit.
    localparam int unsigned SETTLE_MIN = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sac_state_e;

    // Control strobes passed from the sequencer to the datapath.
    typedef struct packed {
        logic capture;   // start accepted: clear word, raise MSB, load period
        logic decide;    // comparator is sampled for the bit under test
        logic advance;   // a lower bit follows: raise it and restart the wait
        logic finish;    // the LSB has just been decided
    } sac_ctrl_t;

    function automatic logic [15:0] clamp_settle(input logic [15:0] req);
        return (req < 16'(SETTLE_MIN)) ? 16'(SETTLE_MIN) : req;
    endfunction

endpackage

// File: rtl/sac_settle_timer.sv
module sac_settle_timer
    import sac_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  sac_ctrl_t        ctrl_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] settle_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_settle;

    always_comb begin
        eff_settle = CNT_W'(clamp_settle(16'(settle_i)));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            period_q <= CNT_W'(SETTLE_MIN);
            cnt_q    <= '0;
        end else if (ctrl_i.capture) begin
            period_q <= eff_settle;
            cnt_q    <= eff_settle - ONE;
        end else if (ctrl_i.advance) begin
            cnt_q    <= period_q - ONE;
        end else if (run_i && cnt_q != '0) begin
            cnt_q    <= cnt_q - ONE;
        end
    end

    assign expire_o = run_i && (cnt_q == '0);

    // R5: the wait counts down by one per clock while a bit settles
    a_r5_count_down: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && cnt_q != '0 && !ctrl_i.capture && !ctrl_i.advance)
            |=> (cnt_q == $past(cnt_q) - ONE));

    // R5: the period never drops below the minimum wait
    a_r5_min_period: assert property (@(posedge clk_i) disable iff (rst_i)
        period_q >= CNT_W'(SETTLE_MIN));

endmodule

// File: rtl/sac_sequencer.sv
module sac_sequencer
    import sac_pkg::*;
#(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned IDX_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             expire_i,
    output sac_ctrl_t        ctrl_o,
    output logic [IDX_W-1:0] ptr_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(CODE_W - 1);

    sac_state_e       state_q;
    logic [IDX_W-1:0] ptr_q;
    logic             done_q;

    always_comb begin
        ctrl_o.capture = (state_q == ST_IDLE) && start_i;
        ctrl_o.decide  = (state_q == ST_RUN) && expire_i;
        ctrl_o.advance = ctrl_o.decide && (ptr_q != '0);
        ctrl_o.finish  = ctrl_o.decide && (ptr_q == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            ptr_q   <= MSB_IDX;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctrl_o.finish;
            if (ctrl_o.capture) begin
                state_q <= ST_RUN;
                ptr_q   <= MSB_IDX;
            end else if (ctrl_o.advance) begin
                ptr_q   <= ptr_q - IDX_W'(1);
            end else if (ctrl_o.finish) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;

    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R6: done and busy never overlap
    a_r6_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && busy_o));

    // R8: a start during a run leaves the bit pointer walking downward
    a_r8_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i && !ctrl_o.decide) |=> (ptr_o == $past(ptr_o)));

endmodule

// File: rtl/sac_code_reg.sv
module sac_code_reg
    import sac_pkg::*;
#(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned IDX_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  sac_ctrl_t         ctrl_i,
    input  logic [IDX_W-1:0]  ptr_i,
    input  logic              comp_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] code_q;

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        logic under_test;
        logic next_up;

        assign under_test = (ptr_i == IDX_W'(i));

        if (i < CODE_W - 1) begin : g_low
            assign next_up = ctrl_i.advance && (ptr_i == IDX_W'(i + 1));
        end else begin : g_top
            assign next_up = 1'b0;
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                code_q[i] <= 1'b0;
            end else if (ctrl_i.capture) begin
                code_q[i] <= (i == CODE_W - 1);
            end else if (ctrl_i.decide && under_test && comp_i) begin
                code_q[i] <= 1'b0;
            end else if (next_up) begin
                code_q[i] <= 1'b1;
            end
        end
    end

    assign code_o = code_q;

    // R4: a bit that sees comp=1 at its decision is dropped
    a_r4_clear_on_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_i.decide && comp_i) |=> (code_o[$past(ptr_i)] == 1'b0));

    // R4: a bit that sees comp=0 at its decision is kept
    a_r4_keep_on_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_i.decide && !comp_i) |=> (code_o[$past(ptr_i)] == 1'b1));

endmodule

// File: rtl/offset_trim_sar.sv
module offset_trim_sar
    import sac_pkg::*;
#(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              comp_i,
    input  logic [CNT_W-1:0]  settle_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    sac_ctrl_t        ctrl;
    logic [IDX_W-1:0] ptr;
    logic             expire;
    logic             busy;

    sac_sequencer #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .expire_i (expire),
        .ctrl_o   (ctrl),
        .ptr_o    (ptr),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    sac_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ctrl_i   (ctrl),
        .run_i    (busy),
        .settle_i (settle_i),
        .expire_o (expire)
    );

    sac_code_reg #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_code (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctrl_i (ctrl),
        .ptr_i  (ptr),
        .comp_i (comp_i),
        .code_o (code_o)
    );

    assign busy_o = busy;

    // Bits strictly below the bit under test.
    logic [CODE_W-1:0] below_m;
    for (genvar i = 0; i < CODE_W; i++) begin : g_below
        assign below_m[i] = (IDX_W'(i) < ptr);
    end

    // R3: nothing below the bit under test is set during a run
    a_r3_low_bits_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> ((code_o & below_m) == '0));

    // R7: idle and no start means the word holds
    a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !start_i) |=> $stable(code_o));

    // R2: an accepted start yields busy with only the MSB set
    a_r2_start_msb: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && start_i) |=> (busy_o && code_o == (CODE_W'(1) << (CODE_W - 1))));

endmodule

// File: tb/tb_offset_trim_sar.sv
module tb_offset_trim_sar;

    localparam int CODE_W = 10;
    localparam int CNT_W  = 8;
    localparam int FULL   = (1 << CODE_W) - 1;
    localparam int NVEC   = 9;

    localparam int VEC_TGT [NVEC] = '{0, 1023, 512, 511, 300, 2000, 1, 685, 77};
    localparam int VEC_SET [NVEC] = '{4, 4,    5,   6,   4,   4,    2, 0,   9};

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              comp;
    logic [CNT_W-1:0]  settle;
    logic [CODE_W-1:0] code;
    logic              busy;
    logic              done;

    int target;
    int comp_mode;   // 0: ideal binary DAC model, 1: stuck high, 2: stuck low
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign comp = (comp_mode == 1) ? 1'b1 :
                  (comp_mode == 2) ? 1'b0 :
                  (int'(code) > target);

    offset_trim_sar #(.CODE_W(CODE_W), .CNT_W(CNT_W)) dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .comp_i   (comp),
        .settle_i (settle),
        .code_o   (code),
        .busy_o   (busy),
        .done_o   (done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one calibration; a second start is issued mid-run when extra_start is set.
    task automatic run_cal(input int tgt, input int set, input int exp_code, input bit extra_start);
        int eff;
        int nbusy;
        int guard;
        eff    = (set < 4) ? 4 : set;
        target = tgt;
        settle = CNT_W'(set);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 MSB only", int'(code), 1 << (CODE_W - 1));
        nbusy = 0;
        guard = 0;
        while (busy && guard < 5000) begin
            nbusy++;
            guard++;
            if (extra_start && nbusy == 7) start = 1'b1;
            if (extra_start && nbusy == 8) start = 1'b0;
            check("R6 no overlap", int'(busy && done), 0);
            @(negedge clk);
        end
        start = 1'b0;
        if (guard >= 5000) check("R5 run ends", 0, 1);
        check(extra_start ? "R8 run length" : "R5 run length", nbusy, CODE_W * eff);
        check("R6 done pulse", int'(done), 1);
        check(extra_start ? "R8 final code" : "R9 final code", int'(code), exp_code);
        @(negedge clk);
        check("R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        int g;
        for (g = 0; g < 150000; g++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        settle = '0;
        target = 0;
        comp_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset code", int'(code), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);

        // Vector table, ideal binary DAC model (R9, R5, R3)
        for (int k = 0; k < NVEC; k++) begin
            run_cal(VEC_TGT[k], VEC_SET[k], (VEC_TGT[k] > FULL) ? FULL : VEC_TGT[k], 1'b0);
        end

        // R4: stuck comparator cases
        comp_mode = 1;
        run_cal(0, 4, 0, 1'b0);
        comp_mode = 2;
        run_cal(0, 4, FULL, 1'b0);

        // R7: word holds while idle although the comparator toggles
        comp_mode = 0;
        run_cal(400, 4, 400, 1'b0);
        for (int k = 0; k < 20; k++) begin
            comp_mode = (k % 2 == 0) ? 1 : 2;
            @(negedge clk);
        end
        check("R7 hold after done", int'(code), 400);
        check("R7 stays idle", int'(busy), 0);
        comp_mode = 0;

        // R8: start during a run is ignored
        run_cal(222, 5, 222, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule